// File: doc/BRIEF.md
# Store Address Queue with Load Hazard Check

This block sits on the memory side of an access unit. It lets a store go out as soon as its address has been computed, without waiting for the value to be written. The address is parked in an in-order queue. Later, the execute side delivers the store value over its data channel. Each value that arrives is joined to the oldest parked address, and the pair leaves one cycle later as a memory write request.

While stores wait for their data, loads may still issue. Each load address is checked against every parked store address at once. If any of them is equal, the block raises a load stall. The load stays at the port, and every load behind it waits too, until the conflicting store has been written out.

An access-side instruction may want an execute-side value for something other than a store, such as address arithmetic. That read is held off while any store address is still parked, so the next value on the channel cannot be taken by the wrong consumer.

Top module: `store_pair_queue`

## Requirements
- R1: After reset the queue is empty. `sa_stall`, `sd_ready`, `ld_stall`, `rd_stall` and `mem_wr_valid` are all 0.
- R2: When `sa_valid` is high and the queue is not full, `sa_addr` is appended at the tail on that clock edge.
- R3: When the queue holds DEPTH addresses, `sa_stall` is 1 and an offered address is not taken. This holds even if an entry leaves in the same cycle. The count never exceeds DEPTH.
- R4: When `sd_valid` and `sd_ready` are both high, the oldest queued address is removed. In the next cycle `mem_wr_valid` is 1, with that address on `mem_wr_addr` and `sd_data` on `mem_wr_data`. In every other cycle `mem_wr_valid` is 0.
- R5: `sd_ready` is 1 exactly when the queue is not empty. A value offered while the queue is empty produces no write.
- R6: `ld_stall` is 1 exactly when `ld_valid` is high and `ld_addr` equals any queued address. An address that is leaving the queue in the same cycle still counts as queued.
- R7: An address being appended in the same cycle as a load is not compared with that load.
- R8: `rd_stall` is 1 exactly when `rd_req` is high and the queue is not empty. This includes the case where the last entry is leaving in that cycle.
- R9: Writes leave in the order their addresses were accepted, including after the queue storage wraps around.
- R10: An append and a removal in the same cycle on a non-full queue both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sa_valid | input | 1 | A store address is offered |
| sa_addr | input | ADDR_W | Store address |
| sa_stall | output | 1 | Queue full; store address not accepted |
| sd_valid | input | 1 | A store value from the execute side is offered |
| sd_data | input | DATA_W | Store value |
| sd_ready | output | 1 | A queued address is available to pair with the value |
| ld_valid | input | 1 | A load address is offered |
| ld_addr | input | ADDR_W | Load address |
| ld_stall | output | 1 | Load conflicts with a queued store address |
| rd_req | input | 1 | Request to consume an execute-side value for non-store use |
| rd_stall | output | 1 | Non-store read must wait for the queue to drain |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_addr | output | ADDR_W | Write address |
| mem_wr_data | output | DATA_W | Write data |

## Verification
The checker keeps its own occupancy count, built only from the accepted handshakes. On every cycle it uses that count to check the full stall, the readiness for data, the non-store read stall, and the count bound. It also checks that every write request is preceded by an accepted value, and that no load stall appears on an empty queue.

The bench's scenarios are needed for the rest:
- which address leaves with a value, including across wrap-around;
- whether a stalled load matched a real entry;
- the conservative treatment of entries leaving in the same cycle;
- the exclusion of addresses arriving in the same cycle.

// File: rtl/sapq_pkg.sv
// Package: shared types for the store address queue.
package sapq_pkg;

    // Occupancy class of the store address queue
    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } qstate_t;

endpackage

// File: rtl/sapq_store_fifo.sv
// Module: sapq_store_fifo
// Circular buffer of pending store addresses. Exposes every slot with a
// live bit so the load comparator can see all pending entries.
// Assumes: push is never asserted when full, pop never when empty
// (the top guards both).
module sapq_store_fifo
    import sapq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic [ADDR_W-1:0]         push_addr,
    input  logic                      pop,
    output logic [ADDR_W-1:0]         head_addr,
    output logic [DEPTH*ADDR_W-1:0]   slot_addr,
    output logic [DEPTH-1:0]          slot_live,
    output qstate_t                   state
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [ADDR_W-1:0] store_mem [DEPTH];
    logic [PTR_W-1:0]  head_q, tail_q;
    logic [CNT_W-1:0]  count_q;
    logic [DEPTH-1:0]  live_q, live_d;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    // Next-state of the per-slot live bits
    always_comb begin
        live_d = live_q;
        if (pop)  live_d[head_q] = 1'b0;
        if (push) live_d[tail_q] = 1'b1;
    end

    // Pointer, count and live-bit registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
            live_q  <= '0;
        end else begin
            if (push) tail_q <= ptr_next(tail_q);
            if (pop)  head_q <= ptr_next(head_q);
            count_q <= count_q + CNT_W'(push) - CNT_W'(pop);
            live_q  <= live_d;
        end
    end

    // Address storage; contents are only meaningful where live
    always_ff @(posedge clk) begin
        if (push) store_mem[tail_q] <= push_addr;
    end

    // Flatten the storage for the comparator
    for (genvar i = 0; i < DEPTH; i++) begin : g_flat
        assign slot_addr[i*ADDR_W +: ADDR_W] = store_mem[i];
    end

    assign slot_live = live_q;
    assign head_addr = store_mem[head_q];

    // Occupancy class
    always_comb begin
        if (count_q == '0)           state = Q_EMPTY;
        else if (count_q == FULL_CNT) state = Q_FULL;
        else                          state = Q_PARTIAL;
    end

endmodule

// File: rtl/sapq_match.sv
// Module: sapq_match
// Associative compare of one probe address against every live slot.
// Assumes: slot_live gates slots whose storage may be stale.
module sapq_match #(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic [ADDR_W-1:0]       probe,
    input  logic [DEPTH*ADDR_W-1:0] slot_addr,
    input  logic [DEPTH-1:0]        slot_live,
    output logic                    any_hit
);
    logic [DEPTH-1:0] hit;

    // One equality comparator per slot
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit[i] = slot_live[i] && (slot_addr[i*ADDR_W +: ADDR_W] == probe);
    end

    assign any_hit = |hit;

endmodule

// File: rtl/sapq_write_port.sv
// Module: sapq_write_port
// Registers a paired address/value as a one-cycle memory write request.
// Assumes: the memory accepts a request every cycle.
module sapq_write_port #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    // Output request register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_valid <= fire;
            if (fire) begin
                wr_addr <= addr;
                wr_data <= data;
            end
        end
    end

endmodule

// File: rtl/store_pair_queue.sv
// Module: store_pair_queue
// Parks early store addresses, pairs each arriving store value with the
// oldest parked address, and stalls loads that hit a parked address.
// Assumes: inputs are held while the matching stall is high; a full queue
// refuses new addresses even when an entry leaves in the same cycle.
module store_pair_queue
    import sapq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sa_valid,
    input  logic [ADDR_W-1:0] sa_addr,
    output logic              sa_stall,
    input  logic              sd_valid,
    input  logic [DATA_W-1:0] sd_data,
    output logic              sd_ready,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_stall,
    input  logic              rd_req,
    output logic              rd_stall,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data
);
    qstate_t                  qstate;
    logic                     push, pop, any_hit;
    logic [ADDR_W-1:0]        head_addr;
    logic [DEPTH*ADDR_W-1:0]  slot_addr;
    logic [DEPTH-1:0]         slot_live;

    // Handshake decode from the occupancy class
    always_comb begin
        sa_stall = (qstate == Q_FULL);
        sd_ready = (qstate != Q_EMPTY);
        push     = sa_valid && !sa_stall;
        pop      = sd_valid && sd_ready;
        ld_stall = ld_valid && any_hit;
        rd_stall = rd_req && sd_ready;
    end

    sapq_store_fifo #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (sa_addr),
        .pop       (pop),
        .head_addr (head_addr),
        .slot_addr (slot_addr),
        .slot_live (slot_live),
        .state     (qstate)
    );

    sapq_match #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_match (
        .probe     (ld_addr),
        .slot_addr (slot_addr),
        .slot_live (slot_live),
        .any_hit   (any_hit)
    );

    sapq_write_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (pop),
        .addr     (head_addr),
        .data     (sd_data),
        .wr_valid (mem_wr_valid),
        .wr_addr  (mem_wr_addr),
        .wr_data  (mem_wr_data)
    );

endmodule

// File: rtl/sapq_checker.sv
// Module: sapq_checker
// Port-level properties of store_pair_queue, built on an occupancy count
// derived only from accepted handshakes.
module sapq_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sa_valid,
    input logic              sa_stall,
    input logic              sd_valid,
    input logic              sd_ready,
    input logic              ld_valid,
    input logic              ld_stall,
    input logic              rd_req,
    input logic              rd_stall,
    input logic              mem_wr_valid,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic [DATA_W-1:0] mem_wr_data
);
    localparam int CNT_W = $clog2(DEPTH + 2);
    logic [CNT_W-1:0] occ;

    // Occupancy from accepted handshakes
    always_ff @(posedge clk) begin
        if (!rst_n) occ <= '0;
        else occ <= occ + CNT_W'(sa_valid && !sa_stall) - CNT_W'(sd_valid && sd_ready);
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));
    assert_full_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sa_stall == (occ == CNT_W'(DEPTH)));
    assert_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sd_ready == (occ != '0));
    assert_read_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stall == (rd_req && occ != '0));
    assert_load_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stall |-> (ld_valid && occ != '0));
    assert_write_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_valid && sd_ready) |=> mem_wr_valid);
    assert_write_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && $past(rst_n)) |-> $past(sd_valid && sd_ready));

endmodule

bind store_pair_queue sapq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sa_valid     (sa_valid),
    .sa_stall     (sa_stall),
    .sd_valid     (sd_valid),
    .sd_ready     (sd_ready),
    .ld_valid     (ld_valid),
    .ld_stall     (ld_stall),
    .rd_req       (rd_req),
    .rd_stall     (rd_stall),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data)
);

// File: tb/sim_store_pair_queue.sv
`timescale 1ns/1ps
module sim_store_pair_queue;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sa_valid = 0, sd_valid = 0, ld_valid = 0, rd_req = 0;
    logic [AW-1:0] sa_addr = '0, ld_addr = '0;
    logic [DW-1:0] sd_data = '0;
    logic sa_stall, sd_ready, ld_stall, rd_stall, mem_wr_valid;
    logic [AW-1:0] mem_wr_addr;
    logic [DW-1:0] mem_wr_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Reference state: queue of pending addresses and expected write
    logic [AW-1:0] model_q[$];
    logic exp_wv = 0;
    logic [AW-1:0] exp_wa = '0;
    logic [DW-1:0] exp_wd = '0;

    always #2.5 clk = ~clk;

    store_pair_queue #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n),
        .sa_valid(sa_valid), .sa_addr(sa_addr), .sa_stall(sa_stall),
        .sd_valid(sd_valid), .sd_data(sd_data), .sd_ready(sd_ready),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_stall(ld_stall),
        .rd_req(rd_req), .rd_stall(rd_stall),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // One clock of stimulus with full comparison against the reference
    task automatic step(input logic sav, input logic [AW-1:0] saa,
                        input logic sdv, input logic [DW-1:0] sdd,
                        input logic ldv, input logic [AW-1:0] lda,
                        input logic rq, input string tag);
        logic full, hit, do_pop, do_push;
        @(negedge clk);
        sa_valid = sav; sa_addr = saa; sd_valid = sdv; sd_data = sdd;
        ld_valid = ldv; ld_addr = lda; rd_req = rq;
        #1;
        full = (model_q.size() == DEPTH);
        hit = 1'b0;
        foreach (model_q[k]) if (model_q[k] == lda) hit = 1'b1;
        chk({"R3 ", tag}, "sa_stall", DW'(sa_stall), DW'(full));
        chk({"R5 ", tag}, "sd_ready", DW'(sd_ready), DW'(model_q.size() != 0));
        chk({"R6 ", tag}, "ld_stall", DW'(ld_stall), DW'(ldv && hit));
        chk({"R8 ", tag}, "rd_stall", DW'(rd_stall), DW'(rq && model_q.size() != 0));
        do_pop  = sdv && (model_q.size() != 0);
        do_push = sav && !full;
        @(posedge clk);
        exp_wv = do_pop;
        if (do_pop) begin
            exp_wa = model_q.pop_front();
            exp_wd = sdd;
        end
        if (do_push) model_q.push_back(saa);
        #1;
        chk({"R4 ", tag}, "mem_wr_valid", DW'(mem_wr_valid), DW'(exp_wv));
        if (exp_wv) begin
            chk({"R4 ", tag}, "mem_wr_addr", DW'(mem_wr_addr), DW'(exp_wa));
            chk({"R4 ", tag}, "mem_wr_data", mem_wr_data, exp_wd);
        end
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1: outputs after reset
        chk("R1", "sa_stall", DW'(sa_stall), 0);
        chk("R1", "sd_ready", DW'(sd_ready), 0);
        chk("R1", "ld_stall", DW'(ld_stall), 0);
        chk("R1", "rd_stall", DW'(rd_stall), 0);
        chk("R1", "mem_wr_valid", DW'(mem_wr_valid), 0);

        // R2: three addresses parked; R6 loads hit and miss; R8 read stall
        step(1, 16'h10, 0, 0, 1, 16'h10, 0, "R2 push-a R7 same-cycle");
        step(1, 16'h20, 0, 0, 0, 0, 1, "R2 push-b");
        step(1, 16'h30, 0, 0, 1, 16'h20, 0, "R2 push-c load-hit");
        step(0, 0, 0, 0, 1, 16'h44, 1, "R6 load-miss");
        // R4: pairing with oldest; R6 entry leaving still stalls the load
        step(0, 0, 1, 32'hA1, 1, 16'h10, 0, "R4 pop-a leaving-hit");
        step(0, 0, 1, 32'hA2, 0, 0, 0, "R4 pop-b");
        // R8 read stall while last entry leaves
        step(0, 0, 1, 32'hA3, 0, 0, 1, "R8 pop-c last");
        // R5: value offered on empty queue is ignored
        step(0, 0, 1, 32'hDEAD, 1, 16'h30, 1, "R5 empty-data");
        step(0, 0, 0, 0, 0, 0, 0, "R5 idle");

        // R3: fill to DEPTH, then over-offer and offer during a pop
        for (int i = 0; i < DEPTH; i++) step(1, AW'(16'h100 + i), 0, 0, 0, 0, 0, "R3 fill");
        step(1, 16'h1FF, 0, 0, 1, 16'h1FF, 0, "R3 full-drop");
        step(1, 16'h1FE, 1, 32'hB0, 0, 0, 0, "R3 full-pop-push");
        // R9: wrap-around ordering with R10 simultaneous push/pop
        for (int i = 0; i < 12; i++)
            step(1, AW'(16'h200 + i), 1, DW'(32'hC00 + i), 1, AW'(16'h200 + i), 0, "R9 R10 wrap");
        for (int i = 0; i < DEPTH; i++) step(0, 0, 1, DW'(32'hD00 + i), 0, 0, 1, "R9 drain");

        // Mixed traffic over a small address space
        for (int i = 0; i < 400; i++)
            step(1'($urandom_range(0, 1)), AW'($urandom_range(0, 7)),
                 1'($urandom_range(0, 1)), DW'($urandom),
                 1'($urandom_range(0, 1)), AW'($urandom_range(0, 7)),
                 1'($urandom_range(0, 1)), "R2 R9 R10 mixed");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule